// File: doc/BRIEF.md
# Grouped Interrupt Source Controller

This block watches a bank of asynchronous interrupt pins and turns their activity into a stream of interrupt messages toward an upstream host link. The pins come in groups of four. Each group has its own trigger mode (level or edge) and its own polarity (active high or active low). Each pin can be masked on its own.

One chosen group can be switched into a legacy mode. Its four pins then produce the four special system interrupt kinds instead of ordinary vectors. By pin offset within the group these are system-management, non-maskable, init and legacy-INTR.

Software programs the block through a small write-only register port, and it signals end-of-interrupt for level sources through the same port. Messages leave through a valid/ready port. A message that is presented stays unchanged until the consumer accepts it. A new message may be loaded in the same cycle that the previous one is accepted, so back-pressure costs no extra cycle.

Top module: `irq_group_ctrl`

## Requirements
- R1: After reset no message is offered (`msg_valid`=0). Every source is masked, every group is level mode and active high, and legacy mode is off.
- R2: In edge mode (bit g of the control word at address 0 set to 1 for group g), each transition of a source from inactive to active produces exactly one message. Holding the pin active produces nothing more.
- R3: In level mode, an active, unmasked source produces one message and is then in service. It sends nothing further until a write to address 2 with its bit set to 1 (end-of-interrupt). If it is still active at that write it sends again. If it is inactive it sends nothing.
- R4: Control-word bit NUM_GRP+g set to 1 makes group g active low. A pin of that group held high then requests nothing, and driving it low requests.
- R5: Address 1 holds one mask bit per source, where 1 means masked. A masked source records no edge and sends no message, and an edge that occurred while it was masked is not sent after unmasking.
- R6: When several sources request at once, the lowest source index is sent first.
- R7: While `msg_valid` is 1 and `msg_ready` is 0, `msg_code` and `msg_legacy` hold steady. When a message is accepted and another source is requesting, the next message is valid in the following cycle.
- R8: With control-word bit 2*NUM_GRP set to 1, sources of group LEGACY_GRP (default pins 12..15) are sent with `msg_legacy`=1 and `msg_code` equal to the pin offset within the group: 0 system-management, 1 non-maskable, 2 init, 3 legacy-INTR. Otherwise `msg_legacy`=0 and `msg_code` is the source index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | NUM_SRC | Raw asynchronous interrupt pins |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 control, 1 mask, 2 end-of-interrupt |
| cfg_wdata | input | NUM_SRC | Register write data |
| msg_valid | output | 1 | Message offered |
| msg_ready | input | 1 | Consumer accepts the offered message |
| msg_legacy | output | 1 | Message is a legacy system interrupt kind |
| msg_code | output | $clog2(NUM_SRC) | Source index, or legacy kind when `msg_legacy` is 1 |

## Verification
The hardest case to reach from the ports is two sources becoming pending in the very same cycle while the consumer stalls. This is the only case where the priority order and the hold rule both show. The bench changes both pins on one clock edge so that they cross the synchronizer together, and it keeps `msg_ready` low. It checks that the lower index is held steady for several cycles. It then accepts once and checks that the second source appears in the very next cycle.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_MASK = 2'd1;
  localparam logic [1:0] ADDR_EOI  = 2'd2;

  typedef enum logic [1:0] {
    LEG_SMI  = 2'd0,
    LEG_NMI  = 2'd1,
    LEG_INIT = 2'd2,
    LEG_INTR = 2'd3
  } legacy_kind_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic edge_mode_i,
  input  logic mask_i,
  input  logic eoi_i,
  input  logic claim_i,
  output logic req_o
);
  logic act_d;
  logic pend_q;
  logic insvc_q;
  logic rise;

  assign rise = act_i & ~act_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_d   <= 1'b0;
      pend_q  <= 1'b0;
      insvc_q <= 1'b0;
    end else begin
      act_d  <= act_i;
      // edge capture; masking or leaving edge mode drops it
      pend_q <= ((pend_q & ~claim_i) | rise) & ~mask_i & edge_mode_i;
      if (edge_mode_i)
        insvc_q <= 1'b0;
      else if (claim_i)
        insvc_q <= 1'b1;
      else if (eoi_i)
        insvc_q <= 1'b0;
    end
  end

  assign req_o = ~mask_i & (edge_mode_i ? pend_q : (act_i & ~insvc_q));
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 16,
  parameter int W = 4
) (
  input  logic [N-1:0] req_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = W'(i);
    end
  end
endmodule

// File: rtl/irq_group_ctrl.sv
module irq_group_ctrl #(
  parameter int NUM_SRC    = 16,
  parameter int GRP_SIZE   = 4,
  parameter int LEGACY_GRP = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         irq_pin,
  input  logic                       cfg_we,
  input  logic [1:0]                 cfg_addr,
  input  logic [NUM_SRC-1:0]         cfg_wdata,
  output logic                       msg_valid,
  input  logic                       msg_ready,
  output logic                       msg_legacy,
  output logic [$clog2(NUM_SRC)-1:0] msg_code
);
  import irq_pkg::*;

  localparam int NUM_GRP  = NUM_SRC / GRP_SIZE;
  localparam int CODE_W   = $clog2(NUM_SRC);
  localparam int LEG_BASE = LEGACY_GRP * GRP_SIZE;
  localparam int LEG_BIT  = 2 * NUM_GRP;

  logic [NUM_GRP-1:0] edge_q;
  logic [NUM_GRP-1:0] low_q;
  logic               leg_en_q;
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] eoi_vec;
  logic [NUM_SRC-1:0] pin_s;
  logic [NUM_SRC-1:0] act_vec;
  logic [NUM_SRC-1:0] req_vec;
  logic [NUM_SRC-1:0] claim_vec;
  logic               pick_any;
  logic [CODE_W-1:0]  pick_idx;
  logic               pick_in_leg;
  logic               load;
  logic               msg_valid_q;
  logic               msg_leg_q;
  logic [CODE_W-1:0]  msg_src_q;

  // register port
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q   <= '0;
      low_q    <= '0;
      leg_en_q <= 1'b0;
      mask_q   <= '1;
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_CTRL) begin
        edge_q   <= cfg_wdata[NUM_GRP-1:0];
        low_q    <= cfg_wdata[2*NUM_GRP-1:NUM_GRP];
        leg_en_q <= cfg_wdata[LEG_BIT];
      end else if (cfg_addr == ADDR_MASK) begin
        mask_q <= cfg_wdata;
      end
    end
  end

  assign eoi_vec = (cfg_we && cfg_addr == ADDR_EOI) ? cfg_wdata : '0;

  irq_sync #(.W(NUM_SRC)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (irq_pin),
    .q_o  (pin_s)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int G = i / GRP_SIZE;
    assign act_vec[i] = pin_s[i] ^ low_q[G];
    irq_src_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .act_i      (act_vec[i]),
      .edge_mode_i(edge_q[G]),
      .mask_i     (mask_q[i]),
      .eoi_i      (eoi_vec[i]),
      .claim_i    (claim_vec[i]),
      .req_o      (req_vec[i])
    );
  end

  irq_prio_pick #(.N(NUM_SRC), .W(CODE_W)) u_pick (
    .req_i(req_vec),
    .any_o(pick_any),
    .idx_o(pick_idx)
  );

  // the slot frees when empty or when its message is taken this cycle
  assign load        = pick_any && (!msg_valid_q || msg_ready);
  assign claim_vec   = load ? (NUM_SRC'(1) << pick_idx) : '0;
  assign pick_in_leg = (int'(pick_idx) >= LEG_BASE) &&
                       (int'(pick_idx) < LEG_BASE + GRP_SIZE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid_q <= 1'b0;
      msg_leg_q   <= 1'b0;
      msg_src_q   <= '0;
    end else if (load) begin
      msg_valid_q <= 1'b1;
      msg_leg_q   <= leg_en_q && pick_in_leg;
      msg_src_q   <= pick_idx;
    end else if (msg_ready) begin
      msg_valid_q <= 1'b0;
    end
  end

  assign msg_valid  = msg_valid_q;
  assign msg_legacy = msg_leg_q;
  assign msg_code   = msg_leg_q ? (msg_src_q - CODE_W'(LEG_BASE)) : msg_src_q;
endmodule

// File: rtl/irq_group_ctrl_chk.sv
module irq_group_ctrl_chk #(
  parameter int NUM_SRC    = 16,
  parameter int GRP_SIZE   = 4,
  parameter int LEGACY_GRP = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       msg_valid,
  input logic                       msg_ready,
  input logic                       msg_legacy,
  input logic [$clog2(NUM_SRC)-1:0] msg_code,
  input logic [$clog2(NUM_SRC)-1:0] msg_src,
  input logic [NUM_SRC-1:0]         req_vec,
  input logic [NUM_SRC-1:0]         claim_vec,
  input logic [NUM_SRC-1:0]         mask_q
);
  localparam int LEG_BASE = LEGACY_GRP * GRP_SIZE;

  // R1
  reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !msg_valid);

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_code) && $stable(msg_legacy));

  // R7
  claim_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(claim_vec));

  // R6
  lowest_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_vec != '0) |-> (((claim_vec - NUM_SRC'(1)) & req_vec) == '0));

  // R5
  masked_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (claim_vec & mask_q) == '0);

  // R8
  legacy_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_legacy |-> (int'(msg_src) >= LEG_BASE) &&
      (int'(msg_src) < LEG_BASE + GRP_SIZE) && (int'(msg_code) < GRP_SIZE));
endmodule

bind irq_group_ctrl irq_group_ctrl_chk #(
  .NUM_SRC   (NUM_SRC),
  .GRP_SIZE  (GRP_SIZE),
  .LEGACY_GRP(LEGACY_GRP)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .msg_valid (msg_valid),
  .msg_ready (msg_ready),
  .msg_legacy(msg_legacy),
  .msg_code  (msg_code),
  .msg_src   (msg_src_q),
  .req_vec   (req_vec),
  .claim_vec (claim_vec),
  .mask_q    (mask_q)
);

// File: tb/irq_group_ctrl_tb.sv
`timescale 1ns/1ps
module irq_group_ctrl_tb;
  import irq_pkg::*;

  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq_pin = '0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_addr = '0;
  logic [N-1:0] cfg_wdata = '0;
  logic         msg_valid;
  logic         msg_ready = 1'b0;
  logic         msg_legacy;
  logic [3:0]   msg_code;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_group_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .msg_valid(msg_valid),
    .msg_ready(msg_ready), .msg_legacy(msg_legacy), .msg_code(msg_code)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    irq_pin = '0; msg_ready = 0; cfg_we = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_msg(input int lim, output bit got);
    got = 0;
    repeat (lim) begin
      @(negedge clk);
      if (msg_valid) begin
        got = 1;
        break;
      end
    end
  endtask

  task automatic accept();
    @(negedge clk);
    msg_ready = 1;
    @(negedge clk);
    msg_ready = 0;
  endtask

  task automatic t_reset();
    bit got;
    do_reset();
    chk(msg_valid == 0, "R1 idle after reset", msg_valid, 0);
    irq_pin = '1;
    wait_msg(10, got);
    chk(got == 0, "R1 all masked after reset", got, 0);
  endtask

  task automatic t_edge();
    bit got;
    do_reset();
    cfg_write(ADDR_CTRL, 16'h0001);
    cfg_write(ADDR_MASK, ~16'h0002);
    irq_pin[1] = 1;
    wait_msg(10, got);
    chk(got && msg_code == 1 && !msg_legacy, "R2 edge message", msg_code, 1);
    accept();
    wait_msg(10, got);
    chk(got == 0, "R2 held pin no repeat", got, 0);
    irq_pin[1] = 0;
    repeat (4) @(negedge clk);
    irq_pin[1] = 1;
    wait_msg(10, got);
    chk(got && msg_code == 1, "R2 second edge", msg_code, 1);
    accept();
  endtask

  task automatic t_level();
    bit got;
    do_reset();
    cfg_write(ADDR_MASK, ~16'h0010);
    irq_pin[4] = 1;
    wait_msg(10, got);
    chk(got && msg_code == 4, "R3 level message", msg_code, 4);
    accept();
    wait_msg(10, got);
    chk(got == 0, "R3 in service no repeat", got, 0);
    cfg_write(ADDR_EOI, 16'h0010);
    wait_msg(10, got);
    chk(got && msg_code == 4, "R3 resend after EOI", msg_code, 4);
    accept();
    irq_pin[4] = 0;
    repeat (5) @(negedge clk);
    cfg_write(ADDR_EOI, 16'h0010);
    wait_msg(10, got);
    chk(got == 0, "R3 inactive after EOI silent", got, 0);
  endtask

  task automatic t_polarity();
    bit got;
    do_reset();
    irq_pin[11:8] = 4'hF;
    cfg_write(ADDR_CTRL, 16'h0040);
    cfg_write(ADDR_MASK, ~16'h0200);
    wait_msg(10, got);
    chk(got == 0, "R4 active-low high pin silent", got, 0);
    irq_pin[9] = 0;
    wait_msg(10, got);
    chk(got && msg_code == 9, "R4 active-low low pin requests", msg_code, 9);
    accept();
  endtask

  task automatic t_mask();
    bit got;
    do_reset();
    cfg_write(ADDR_CTRL, 16'h0002);
    irq_pin[6] = 1;
    repeat (6) @(negedge clk);
    cfg_write(ADDR_MASK, ~16'h0040);
    wait_msg(10, got);
    chk(got == 0, "R5 masked edge not recorded", got, 0);
    irq_pin[6] = 0;
    repeat (4) @(negedge clk);
    irq_pin[6] = 1;
    wait_msg(10, got);
    chk(got && msg_code == 6, "R5 unmasked edge sent", msg_code, 6);
    accept();
  endtask

  task automatic t_priority();
    bit got;
    bit steady;
    do_reset();
    cfg_write(ADDR_CTRL, 16'h0003);
    cfg_write(ADDR_MASK, ~16'h0024);
    irq_pin[2] = 1; irq_pin[5] = 1;
    wait_msg(10, got);
    chk(got && msg_code == 2, "R6 lowest index first", msg_code, 2);
    steady = 1;
    repeat (5) begin
      @(negedge clk);
      if (!msg_valid || msg_code != 2) steady = 0;
    end
    chk(steady, "R7 held under back-pressure", msg_code, 2);
    accept();
    chk(msg_valid && msg_code == 5, "R7 next message follows at once", msg_code, 5);
    accept();
    chk(msg_valid == 0, "R7 queue drained", msg_valid, 0);
  endtask

  task automatic t_legacy();
    bit got;
    do_reset();
    cfg_write(ADDR_CTRL, 16'h0100);
    cfg_write(ADDR_MASK, ~16'h2000);
    irq_pin[13] = 1;
    wait_msg(10, got);
    chk(got && msg_legacy && msg_code == LEG_NMI, "R8 legacy NMI", msg_code, LEG_NMI);
    accept();
    cfg_write(ADDR_CTRL, 16'h0000);
    cfg_write(ADDR_EOI, 16'h2000);
    wait_msg(10, got);
    chk(got && !msg_legacy && msg_code == 13, "R8 ordinary vector when off", msg_code, 13);
    accept();
    cfg_write(ADDR_CTRL, 16'h0100);
    cfg_write(ADDR_MASK, ~16'h8000);
    irq_pin[15] = 1;
    wait_msg(10, got);
    chk(got && msg_legacy && msg_code == LEG_INTR, "R8 legacy INTR", msg_code, LEG_INTR);
    accept();
  endtask

  initial begin
    t_reset();
    t_edge();
    t_level();
    t_polarity();
    t_mask();
    t_priority();
    t_legacy();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule